// File: doc/BRIEF.md
# Shared-Gain Multi-Channel LED Dimming Generator

This block produces the on/off gating for a bank of LED current channels. One gain code, common to every channel, sets the duty cycle. The code reaches the duty through one of two curves. The logarithmic curve gives even perceived brightness steps. The linear curve scales the duty in direct proportion to the code. A free-running period counter advances on an external 400 ns tick. The period length comes from three selectable rates, nominally 125, 250 and 500 Hz.

Each channel has an on bit and a dimming-enable bit, and a global enable gates dimming for the whole bank. A channel that is on but not dimmed conducts continuously. A channel that is off never conducts. Channel turn-on edges are spread in time: each pair of adjacent channels starts one tick after the pair before it, so the supply never sees all channels switch together. A new gain, curve or rate is taken up only at a period boundary, which keeps runt pulses off the outputs.

Top module: `led_dim_pwm`

## Requirements
- R1: While reset is asserted every channel output is 0, whatever the masks and enables are.
- R2: A channel whose on-mask bit is 0 has output 0 on the following cycle, whatever its other inputs.
- R3: A channel whose on-mask bit is 1 drives 1 continuously on the following cycle when the global enable is 0 or its dimming-mask bit is 0. Setting the global enable back to 1 resumes dimming on the channels whose dimming-mask bit is 1, and the mask is not rewritten.
- R4: The period is P_HI ticks when rate_hi_i is 1. Otherwise it is P_MID ticks when rate_mid_i is 1 and P_LO ticks when both are 0. The defaults are 5000, 10000 and 20000 ticks of 400 ns.
- R5: With lin_i = 0 the on-time per period is round(P × 0.9471^(127 − gain)) ticks, to within one tick. Gain 127 gives a constant-on output.
- R6: With lin_i = 1 the on-time per period is round(P × gain / 127) ticks, to within one tick. Gain 0 gives no on-time and gain 127 gives the full period.
- R7: With a tick on every clock, the turn-on edge of channel c (0-based) lags that of channel 0 by floor(c/2) ticks.
- R8: The period counter and all dimming state hold while tick_i is 0. The output pattern in clock cycles stretches with the tick spacing.
- R9: Changes of gain, curve or rate take effect only at the end of the current period. The pulse in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 400 ns time-step enable |
| gain_i | input | GAIN_W | Shared dimming code |
| rate_hi_i | input | 1 | Selects the shortest period |
| rate_mid_i | input | 1 | Selects the middle period when rate_hi_i is 0 |
| lin_i | input | 1 | 1 selects the linear curve, 0 the logarithmic curve |
| pwm_en_i | input | 1 | Global dimming enable |
| pwm_mask_i | input | N_CH | Per-channel dimming enable |
| on_mask_i | input | N_CH | Per-channel on bit |
| chan_on_o | output | N_CH | Per-channel conduction gate |

## Verification
On every cycle the assertions check the per-channel forcing rules: a channel that is off stays dark, and a channel that is on but not dimmed stays lit. They also check that the counter freezes without a tick, that it stays below the latched period, that the on-time never exceeds the period, and that period and on-time change only at the wrap. The curve values, the period lengths, the pair-wise stagger offsets and the old pulse finishing across a gain change are shown only by the directed scenarios. Those scenarios measure pulse widths, rise spacing and rise-to-rise distances at the outputs.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;

    localparam int FRAC_SH = 24;
    localparam int FRAC_W  = FRAC_SH + 1;
    localparam longint unsigned ALPHA_Q30 = 64'd1016940882;

    typedef enum logic [1:0] {
        RATE_LO  = 2'd0,
        RATE_MID = 2'd1,
        RATE_HI  = 2'd2
    } rate_e;

    function automatic rate_e pick_rate(input logic hi, input logic mid);
        if (hi)       return RATE_HI;
        else if (mid) return RATE_MID;
        else          return RATE_LO;
    endfunction

    // alpha^k as a Q24 fraction, built up in Q30 to keep rounding error tiny
    function automatic longint unsigned alpha_pow_q24(input int k);
        longint unsigned v;
        v = 64'd1 << 30;
        for (int i = 0; i < k; i++) begin
            v = (v * ALPHA_Q30 + (64'd1 << 29)) >> 30;
        end
        return (v + 64'd32) >> 6;
    endfunction

endpackage

// File: rtl/led_dim_duty_map.sv
module led_dim_duty_map
    import led_dim_pkg::*;
#(
    parameter int GAIN_W = 7,
    parameter int PW     = 15
) (
    input  logic [GAIN_W-1:0] gain_i,
    input  logic              lin_i,
    input  logic [PW-1:0]     per_i,
    output logic [PW-1:0]     on_o
);
    localparam int NSTEP = 1 << GAIN_W;
    localparam longint unsigned TOPC = longint'(NSTEP - 1);
    localparam longint unsigned LIN_STEP =
        ((64'd1 << (FRAC_SH + 1)) + TOPC) / (2 * TOPC);
    localparam int PROD_W = PW + FRAC_SH;
    localparam logic [PROD_W-1:0] HALF = PROD_W'(64'd1 << (FRAC_SH - 1));

    logic [FRAC_W-1:0] log_tbl [NSTEP];
    logic [FRAC_W-1:0] frac;
    logic [PROD_W-1:0] prod;

    for (genvar g = 0; g < NSTEP; g++) begin : g_tbl
        localparam longint unsigned FV = alpha_pow_q24(NSTEP - 1 - g);
        assign log_tbl[g] = FRAC_W'(FV);
    end

    always_comb begin
        if (lin_i) frac = FRAC_W'(gain_i) * FRAC_W'(LIN_STEP);
        else       frac = log_tbl[gain_i];
        prod = PROD_W'(per_i) * PROD_W'(frac) + HALF;
        on_o = PW'(prod >> FRAC_SH);
    end

endmodule

// File: rtl/led_dim_timebase.sv
module led_dim_timebase #(
    parameter int PW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [PW-1:0] per_req_i,
    input  logic [PW-1:0] on_req_i,
    output logic [PW-1:0] cnt_o,
    output logic [PW-1:0] per_o,
    output logic [PW-1:0] on_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [PW-1:0] per;
        logic [PW-1:0] on;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      last;

    always_comb begin
        st_d = st_q;
        last = (st_q.cnt == st_q.per - PW'(1));
        if (tick_i) begin
            if (last) begin
                st_d.cnt = '0;
                st_d.per = per_req_i;
                st_d.on  = on_req_i;
            end else begin
                st_d.cnt = st_q.cnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0, per: PW'(1), on: '0};
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign per_o = st_q.per;
    assign on_o  = st_q.on;

    // R8
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q));
    // R9
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (st_q.cnt != st_q.per - PW'(1))) |=>
            ($stable(st_q.per) && $stable(st_q.on)));
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.per);
    // R5 R6
    on_le_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.on <= st_q.per);

endmodule

// File: rtl/led_dim_chan_gate.sv
module led_dim_chan_gate #(
    parameter int PW  = 15,
    parameter int DLY = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cnt_i,
    input  logic [PW-1:0] per_i,
    input  logic [PW-1:0] on_i,
    input  logic          on_bit_i,
    input  logic          dim_bit_i,
    output logic          chan_o
);
    localparam logic [PW:0] DLY_W = (PW + 1)'(DLY);

    logic [PW:0] pos;
    logic        chan_d, chan_q;

    always_comb begin
        if ({1'b0, cnt_i} >= DLY_W) pos = {1'b0, cnt_i} - DLY_W;
        else                         pos = {1'b0, cnt_i} + {1'b0, per_i} - DLY_W;
        chan_d = on_bit_i && (!dim_bit_i || (pos < {1'b0, on_i}));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chan_q <= 1'b0;
        else        chan_q <= chan_d;
    end

    assign chan_o = chan_q;

    // R2
    off_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on_bit_i |=> !chan_o);
    // R3
    steady_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_bit_i && !dim_bit_i) |=> chan_o);

endmodule

// File: rtl/led_dim_pwm.sv
module led_dim_pwm
    import led_dim_pkg::*;
#(
    parameter int N_CH       = 12,
    parameter int GAIN_W     = 7,
    parameter int P_LO       = 20000,
    parameter int P_MID      = 10000,
    parameter int P_HI       = 5000,
    parameter int GROUP      = 2,
    parameter int STAG_TICKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic              rate_hi_i,
    input  logic              rate_mid_i,
    input  logic              lin_i,
    input  logic              pwm_en_i,
    input  logic [N_CH-1:0]   pwm_mask_i,
    input  logic [N_CH-1:0]   on_mask_i,
    output logic [N_CH-1:0]   chan_on_o
);
    localparam int PMAX1 = (P_LO > P_MID) ? P_LO : P_MID;
    localparam int PMAX  = (PMAX1 > P_HI) ? PMAX1 : P_HI;
    localparam int PW    = $clog2(PMAX + 1);

    rate_e         rate;
    logic [PW-1:0] per_req, on_req;
    logic [PW-1:0] cnt, per, on_t;

    always_comb begin
        rate = pick_rate(rate_hi_i, rate_mid_i);
        case (rate)
            RATE_HI:  per_req = PW'(P_HI);
            RATE_MID: per_req = PW'(P_MID);
            default:  per_req = PW'(P_LO);
        endcase
    end

    led_dim_duty_map #(.GAIN_W(GAIN_W), .PW(PW)) i_map (
        .gain_i (gain_i),
        .lin_i  (lin_i),
        .per_i  (per_req),
        .on_o   (on_req)
    );

    led_dim_timebase #(.PW(PW)) i_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .per_req_i (per_req),
        .on_req_i  (on_req),
        .cnt_o     (cnt),
        .per_o     (per),
        .on_o      (on_t)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int DLY = (c / GROUP) * STAG_TICKS;
        led_dim_chan_gate #(.PW(PW), .DLY(DLY)) i_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_i     (cnt),
            .per_i     (per),
            .on_i      (on_t),
            .on_bit_i  (on_mask_i[c]),
            .dim_bit_i (pwm_en_i && pwm_mask_i[c]),
            .chan_o    (chan_on_o[c])
        );
    end

endmodule

// File: tb/test_led_dim_pwm.sv
module test_led_dim_pwm;
    localparam int N  = 12;
    localparam int PL = 800;
    localparam int PM = 400;
    localparam int PH = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [6:0] gain = '0;
    logic rhi = 1'b0, rmid = 1'b0, lin = 1'b0, pen = 1'b0;
    logic [N-1:0] pmask = '0, omask = '0;
    logic [N-1:0] outs;
    int tick_mode = 0;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    led_dim_pwm #(.N_CH(N), .GAIN_W(7), .P_LO(PL), .P_MID(PM), .P_HI(PH))
    i_led_dim_pwm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .gain_i(gain),
        .rate_hi_i(rhi), .rate_mid_i(rmid), .lin_i(lin), .pwm_en_i(pen),
        .pwm_mask_i(pmask), .on_mask_i(omask), .chan_on_o(outs)
    );

    initial forever #10 clk = ~clk;

    initial forever begin
        @(negedge clk);
        case (tick_mode)
            0: tick = 1'b1;
            1: tick = ~tick;
            default: tick = 1'b0;
        endcase
    end

    task automatic chk(input string req, input int act, input int exp, input int tol);
        int d;
        n_chk++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_on(input int p, input int g, input bit l);
        real v;
        if (l) v = p * g / 127.0;
        else   v = p * (0.9471 ** (127 - g));
        return $rtoi(v + 0.5);
    endfunction

    task automatic settle();
        repeat (2 * PL + 6) @(negedge clk);
    endtask

    task automatic count_high(input int c, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (outs[c]) hi++;
        end
    endtask

    task automatic wait_rise(input int c, output int at);
        logic prev;
        at = -1;
        @(negedge clk);
        prev = outs[c];
        for (int i = 1; i < 4 * PL; i++) begin
            @(negedge clk);
            if (outs[c] && !prev) begin
                at = i;
                break;
            end
            prev = outs[c];
        end
    endtask

    task automatic t_reset();
        omask = '1; pen = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 outputs in reset", int'(outs), 0, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 steady on after reset", int'(outs), int'({N{1'b1}}), 0);
    endtask

    task automatic t_steady();
        int hi;
        pmask = '1; pen = 1'b0; rhi = 1'b1; lin = 1'b1; gain = 7'd32;
        settle();
        count_high(5, PH, hi);
        chk("R3 global enable off holds on", hi, PH, 0);
        pen = 1'b1;
        settle();
        count_high(5, PH, hi);
        chk("R3 dimming resumes with kept mask", hi, exp_on(PH, 32, 1), 1);
        pmask[7] = 1'b0;
        settle();
        count_high(7, PH, hi);
        chk("R3 undimmed channel stays on", hi, PH, 0);
        pmask = '1;
    endtask

    task automatic t_off();
        int hi;
        omask[3] = 1'b0;
        settle();
        count_high(3, PH, hi);
        chk("R2 off channel dark while dimming", hi, 0, 0);
        pen = 1'b0;
        repeat (4) @(negedge clk);
        count_high(3, PH, hi);
        chk("R2 off channel dark when undimmed", hi, 0, 0);
        pen = 1'b1; omask = '1;
    endtask

    task automatic t_lin();
        int hi;
        int gl [4] = '{0, 32, 64, 127};
        rhi = 1'b1; lin = 1'b1;
        foreach (gl[k]) begin
            gain = 7'(gl[k]);
            settle();
            count_high(0, PH, hi);
            chk("R6 linear on-time", hi, exp_on(PH, gl[k], 1),
                (gl[k] == 0 || gl[k] == 127) ? 0 : 1);
        end
    endtask

    task automatic t_log();
        int hi;
        int gl [4] = '{127, 100, 60, 0};
        rhi = 1'b0; rmid = 1'b1; lin = 1'b0;
        foreach (gl[k]) begin
            gain = 7'(gl[k]);
            settle();
            count_high(2, PM, hi);
            chk("R5 log on-time", hi, exp_on(PM, gl[k], 0), (gl[k] == 127) ? 0 : 1);
        end
    endtask

    task automatic t_rate();
        int a, b;
        lin = 1'b1; gain = 7'd64;
        for (int r = 0; r < 3; r++) begin
            rhi = (r == 2); rmid = (r == 1);
            settle();
            wait_rise(0, a);
            wait_rise(0, b);
            chk("R4 period length", b + 1, (r == 2) ? PH : (r == 1) ? PM : PL, 0);
        end
    endtask

    task automatic t_stagger();
        int rise [N];
        logic [N-1:0] prev;
        rhi = 1'b0; rmid = 1'b0; lin = 1'b1; gain = 7'd64;
        settle();
        foreach (rise[c]) rise[c] = -1;
        @(negedge clk);
        prev = outs;
        for (int i = 1; i < 2 * PL; i++) begin
            @(negedge clk);
            for (int c = 0; c < N; c++)
                if (rise[c] < 0 && outs[c] && !prev[c]) rise[c] = i;
            prev = outs;
        end
        for (int c = 1; c < N; c++)
            chk("R7 pair stagger", (((rise[c] - rise[0]) % PL) + PL) % PL, c / 2, 0);
    endtask

    task automatic t_tick();
        int hi;
        logic [N-1:0] snap;
        rhi = 1'b1; lin = 1'b1; gain = 7'd64;
        tick_mode = 1;
        settle(); settle();
        count_high(0, 2 * PH, hi);
        chk("R8 half-rate tick stretches pulse", hi, 2 * exp_on(PH, 64, 1), 2);
        tick_mode = 2;
        repeat (3) @(negedge clk);
        snap = outs;
        gain = 7'd5;
        hi = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (outs != snap) hi++;
        end
        chk("R8 frozen without tick", hi, 0, 0);
        tick_mode = 0;
    endtask

    task automatic t_boundary();
        int at, run;
        rhi = 1'b1; lin = 1'b1; gain = 7'd32;
        settle();
        wait_rise(0, at);
        gain = 7'd127;
        run = 1;
        for (int i = 0; i < 3 * PH; i++) begin
            @(negedge clk);
            if (!outs[0]) break;
            run++;
        end
        chk("R9 pulse in progress keeps old length", run, exp_on(PH, 32, 1), 1);
        settle();
        count_high(0, PH, run);
        chk("R9 new gain after boundary", run, PH, 0);
    endtask

    initial begin
        t_reset();
        t_steady();
        t_off();
        t_lin();
        t_log();
        t_rate();
        t_stagger();
        t_tick();
        t_boundary();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule